// File: doc/BRIEF.md
# Pseudo-Ternary Line Codec with Frame Alignment

This block converts a serial bit stream into a three-level line signal and back. Transmit takes one data bit per bit-clock enable together with a frame strobe, and drives two pulse-select outputs, one for the positive pulse and one for the negative pulse. A ONE is sent as silence. A ZERO is sent as a pulse whose polarity alternates with the previous pulse. At each frame boundary the encoder sends a deliberate pulse of the same polarity as the previous one. This polarity violation marks the frame. In the terminal-to-network direction the frame strobe can be delayed by two bit periods.

Receive samples the two pulse inputs once per bit enable. It returns the decoded bit, a violation flag and a flag for a bit period in which both pulse inputs are active. A frame aligner looks for violations that recur every 48 bits. After three such violations in a row it reports lock and marks each frame start. While locked it uses the expected positions to carry on through single missing marks. The nominal line rate is 192 kbit/s, and 36 of the 48 positions in each frame carry user data.

Top module: `pt_line_codec`

## Requirements
- R1: When the effective frame strobe is inactive, a ONE on `tx_bit` drives both `tx_pos` and `tx_neg` low for that bit period.
- R2: A ZERO produces a pulse on exactly one output, and its polarity is opposite to the previous pulse. The polarity tracker resets to negative, so the first ZERO after reset is positive (`tx_pos`=1).
- R3: With `tx_offset_en`=0, a `tx_frame` strobe forces a pulse in the same bit period whatever `tx_bit` is. This pulse has the same polarity as the previous pulse, and later ZEROs alternate starting from it.
- R4: With `tx_offset_en`=1, the forced same-polarity pulse is sent two bit periods after the strobe. The bit sent during the strobe itself is ordinary data.
- R5: A bit period with any pulse decodes as `rx_bit`=0. A bit period with no pulse decodes as `rx_bit`=1.
- R6: The receiver stores the polarity of the last single pulse, starting from negative after reset. A single pulse of that same polarity raises `rx_viol` for its bit, whether the two pulses are adjacent or separated by ONEs.
- R7: If both pulse inputs are high in one bit period, the receiver raises `rx_sym_err` and decodes a ZERO. It flags no violation and leaves the stored polarity unchanged.
- R8: Lock (`rx_locked`=1) is declared together with the third violation in a row where each violation comes exactly 48 bits after the previous one. While locked, `rx_frame_start` pulses with `rx_valid` at every 48th bit, counted from that violation.
- R9: While locked, violations away from the expected position are ignored. Lock is dropped at the second expected position in a row that has no violation, and no frame start is reported there.
- R10: While hunting, a violation at an unexpected position, or a missing violation at the expected position, restarts the count of consecutive violations.
- R11: All actions are qualified by `bit_en`, and inputs are ignored while it is low. `tx_pos` and `tx_neg` update on the edge that samples `bit_en`. All receive outputs, with a one-cycle `rx_valid`, appear one clock later.
- R12: A synchronous reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Single-cycle bit-clock enable |
| tx_bit | input | 1 | Transmit data bit |
| tx_frame | input | 1 | Frame strobe for the current transmit bit |
| tx_offset_en | input | 1 | 1 delays the frame strobe by two bit periods |
| tx_pos | output | 1 | Positive pulse select |
| tx_neg | output | 1 | Negative pulse select |
| rx_pos | input | 1 | Sampled positive pulse |
| rx_neg | input | 1 | Sampled negative pulse |
| rx_valid | output | 1 | One-cycle strobe for a decoded bit |
| rx_bit | output | 1 | Decoded data bit |
| rx_viol | output | 1 | Polarity violation on this bit |
| rx_sym_err | output | 1 | Both pulse inputs active on this bit |
| rx_locked | output | 1 | Frame alignment locked |
| rx_frame_start | output | 1 | Bit is the first bit of a frame while locked |

## Verification
The bench uses the default parameters: 48-bit frames, lock after three aligned violations, release after two missed marks, and a two-bit maximum strobe delay. With these values twelve frames are enough to reach lock, carry on through one missing mark, lose lock, restart the hunt after a misplaced violation, and lock again at a new phase. The delay of two is short enough that both strobe settings run in the same stream, so the forced pulse can be checked in the strobe bit and two bits later.

// File: rtl/pt_codec_pkg.sv
package pt_codec_pkg;

  typedef enum logic {
    POL_NEG = 1'b0,
    POL_POS = 1'b1
  } pol_e;

  typedef struct packed {
    logic valid;
    logic bit_val;
    logic viol;
    logic sym_err;
  } rx_sym_t;

endpackage

// File: rtl/pt_strobe_delay.sv
module pt_strobe_delay #(
  parameter int MAX_OFFSET = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic strobe_in,
  input  logic use_offset,
  output logic strobe_out
);

  logic [MAX_OFFSET-1:0] hist;

  generate
    if (MAX_OFFSET == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else if (bit_en) hist <= strobe_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else if (bit_en) hist <= {hist[MAX_OFFSET-2:0], strobe_in};
      end
    end
  endgenerate

  assign strobe_out = use_offset ? hist[MAX_OFFSET-1] : strobe_in;

endmodule

// File: rtl/pt_encoder.sv
module pt_encoder
  import pt_codec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic data_bit,
  input  logic frame_mark,
  output logic line_pos,
  output logic line_neg
);

  pol_e last_pol;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_pos <= 1'b0;
      line_neg <= 1'b0;
      last_pol <= POL_NEG;
    end else if (bit_en) begin
      if (frame_mark) begin
        // repeat the previous polarity to force a violation
        line_pos <= (last_pol == POL_POS);
        line_neg <= (last_pol == POL_NEG);
      end else if (!data_bit) begin
        line_pos <= (last_pol == POL_NEG);
        line_neg <= (last_pol == POL_POS);
        last_pol <= (last_pol == POL_POS) ? POL_NEG : POL_POS;
      end else begin
        line_pos <= 1'b0;
        line_neg <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pt_decoder.sv
module pt_decoder
  import pt_codec_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    bit_en,
  input  logic    line_pos,
  input  logic    line_neg,
  output rx_sym_t sym
);

  pol_e last_pol;
  pol_e seen_pol;
  logic single;
  logic both;

  assign single   = line_pos ^ line_neg;
  assign both     = line_pos & line_neg;
  assign seen_pol = line_pos ? POL_POS : POL_NEG;

  always_ff @(posedge clk) begin
    if (rst) begin
      sym      <= '0;
      last_pol <= POL_NEG;
    end else begin
      sym.valid   <= bit_en;
      sym.viol    <= bit_en & single & (seen_pol == last_pol);
      sym.sym_err <= bit_en & both;
      if (bit_en) begin
        sym.bit_val <= ~(line_pos | line_neg);
        if (single) last_pol <= seen_pol;
      end
    end
  end

endmodule

// File: rtl/pt_frame_lock.sv
module pt_frame_lock #(
  parameter int FRAME_BITS    = 48,
  parameter int LOCK_FRAMES   = 3,
  parameter int UNLOCK_FRAMES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sym_valid,
  input  logic sym_viol,
  output logic locked,
  output logic frame_start
);

  localparam int CNT_W  = $clog2(FRAME_BITS);
  localparam int GOOD_W = $clog2(LOCK_FRAMES + 1);
  localparam int MISS_W = $clog2(UNLOCK_FRAMES + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(FRAME_BITS - 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_FRAMES - 1);
  localparam logic [GOOD_W-1:0] GOOD_ONE  = GOOD_W'(1);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(UNLOCK_FRAMES - 1);
  localparam logic [MISS_W-1:0] MISS_ONE  = MISS_W'(1);

  logic [CNT_W-1:0]  cnt, n_cnt, step_cnt;
  logic [GOOD_W-1:0] good, n_good;
  logic [MISS_W-1:0] miss, n_miss;
  logic              n_locked, n_start, at_mark;

  assign step_cnt = (cnt == CNT_LAST) ? '0 : cnt + CNT_W'(1);
  assign at_mark  = (step_cnt == '0);

  always_comb begin
    n_cnt    = cnt;
    n_good   = good;
    n_miss   = miss;
    n_locked = locked;
    if (sym_valid) begin
      if (locked) begin
        n_cnt = step_cnt;
        if (at_mark) begin
          if (sym_viol) begin
            n_miss = '0;
          end else if (miss == MISS_LAST) begin
            n_locked = 1'b0;
            n_good   = '0;
            n_miss   = '0;
          end else begin
            n_miss = miss + MISS_ONE;
          end
        end
      end else if (good == '0) begin
        if (sym_viol) begin
          n_good = GOOD_ONE;
          n_cnt  = '0;
        end
      end else if (at_mark) begin
        if (sym_viol) begin
          n_cnt = '0;
          if (good == GOOD_LAST) begin
            n_locked = 1'b1;
            n_good   = '0;
            n_miss   = '0;
          end else begin
            n_good = good + GOOD_ONE;
          end
        end else begin
          n_good = '0;
        end
      end else if (sym_viol) begin
        n_good = GOOD_ONE;
        n_cnt  = '0;
      end else begin
        n_cnt = step_cnt;
      end
    end
    n_start = sym_valid & n_locked & (n_cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      good        <= '0;
      miss        <= '0;
      locked      <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      cnt         <= n_cnt;
      good        <= n_good;
      miss        <= n_miss;
      locked      <= n_locked;
      frame_start <= n_start;
    end
  end

endmodule

// File: rtl/pt_line_codec.sv
module pt_line_codec
  import pt_codec_pkg::*;
#(
  parameter int FRAME_BITS    = 48,
  parameter int LOCK_FRAMES   = 3,
  parameter int UNLOCK_FRAMES = 2,
  parameter int MAX_OFFSET    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic tx_bit,
  input  logic tx_frame,
  input  logic tx_offset_en,
  output logic tx_pos,
  output logic tx_neg,
  input  logic rx_pos,
  input  logic rx_neg,
  output logic rx_valid,
  output logic rx_bit,
  output logic rx_viol,
  output logic rx_sym_err,
  output logic rx_locked,
  output logic rx_frame_start
);

  logic    mark_eff;
  rx_sym_t dec_sym;
  rx_sym_t out_sym;

  pt_strobe_delay #(.MAX_OFFSET(MAX_OFFSET)) u_delay (
    .clk(clk), .rst(rst), .bit_en(bit_en),
    .strobe_in(tx_frame), .use_offset(tx_offset_en), .strobe_out(mark_eff)
  );

  pt_encoder u_enc (
    .clk(clk), .rst(rst), .bit_en(bit_en),
    .data_bit(tx_bit), .frame_mark(mark_eff),
    .line_pos(tx_pos), .line_neg(tx_neg)
  );

  pt_decoder u_dec (
    .clk(clk), .rst(rst), .bit_en(bit_en),
    .line_pos(rx_pos), .line_neg(rx_neg), .sym(dec_sym)
  );

  pt_frame_lock #(
    .FRAME_BITS(FRAME_BITS), .LOCK_FRAMES(LOCK_FRAMES), .UNLOCK_FRAMES(UNLOCK_FRAMES)
  ) u_lock (
    .clk(clk), .rst(rst), .sym_valid(dec_sym.valid), .sym_viol(dec_sym.viol),
    .locked(rx_locked), .frame_start(rx_frame_start)
  );

  // align decoded symbols with the aligner's registered outputs
  always_ff @(posedge clk) begin
    if (rst) out_sym <= '0;
    else     out_sym <= dec_sym;
  end

  assign rx_valid   = out_sym.valid;
  assign rx_bit     = out_sym.bit_val;
  assign rx_viol    = out_sym.viol;
  assign rx_sym_err = out_sym.sym_err;

endmodule

// File: rtl/pt_line_codec_chk.sv
module pt_line_codec_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic tx_bit,
  input logic tx_frame,
  input logic tx_offset_en,
  input logic tx_pos,
  input logic tx_neg,
  input logic rx_valid,
  input logic rx_bit,
  input logic rx_viol,
  input logic rx_sym_err,
  input logic rx_locked,
  input logic rx_frame_start
);

  // R2
  tx_excl_chk: assert property (@(posedge clk) disable iff (rst) !(tx_pos && tx_neg));

  // R1
  tx_one_chk: assert property (@(posedge clk) disable iff (rst)
    bit_en && tx_bit && !tx_frame && !tx_offset_en |=> !tx_pos && !tx_neg);

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(tx_pos) && $stable(tx_neg));

  // R11
  rx_lat_chk: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> ##1 rx_valid);

  // R6
  rx_viol_chk: assert property (@(posedge clk) disable iff (rst)
    rx_viol |-> rx_valid && !rx_bit && !rx_sym_err);

  // R7
  rx_err_chk: assert property (@(posedge clk) disable iff (rst)
    rx_sym_err |-> rx_valid && !rx_bit && !rx_viol);

  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $rose(rx_locked) |-> rx_viol && rx_frame_start);

  // R8
  frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    rx_frame_start |-> rx_locked && rx_valid);

  // R9
  lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $fell(rx_locked) |-> rx_valid && !rx_viol && !rx_frame_start);

endmodule

bind pt_line_codec pt_line_codec_chk u_chk (.*);

// File: tb/pt_line_codec_bench.sv
module pt_line_codec_bench;

  localparam int FRAME_BITS    = 48;
  localparam int LOCK_FRAMES   = 3;
  localparam int UNLOCK_FRAMES = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, bit_en, tx_bit, tx_frame, tx_offset_en, rx_pos_i, rx_neg_i;
  logic tx_pos, tx_neg, rx_valid, rx_bit, rx_viol, rx_sym_err, rx_locked, rx_frame_start;

  pt_line_codec u_pt_line_codec (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_bit(tx_bit), .tx_frame(tx_frame),
    .tx_offset_en(tx_offset_en), .tx_pos(tx_pos), .tx_neg(tx_neg),
    .rx_pos(rx_pos_i), .rx_neg(rx_neg_i), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .rx_viol(rx_viol), .rx_sym_err(rx_sym_err), .rx_locked(rx_locked),
    .rx_frame_start(rx_frame_start)
  );

  typedef struct {
    logic b;
    logic v;
    logic e;
    logic lk;
    logic fs;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  bit tx_last = 1'b0;  // 1 = positive
  bit h1 = 1'b0, h2 = 1'b0;
  bit g_last = 1'b0;
  bit m_locked = 1'b0;
  int m_good = 0, m_miss = 0, m_cnt = 0;

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic lock_model(input bit viol, output bit lk, output bit fs);
    int nxt;
    nxt = (m_cnt == FRAME_BITS - 1) ? 0 : m_cnt + 1;
    if (m_locked) begin
      m_cnt = nxt;
      if (nxt == 0) begin
        if (viol) m_miss = 0;
        else if (m_miss == UNLOCK_FRAMES - 1) begin
          m_locked = 1'b0; m_good = 0; m_miss = 0;
        end else m_miss++;
      end
    end else if (m_good == 0) begin
      if (viol) begin m_good = 1; m_cnt = 0; end
    end else if (nxt == 0) begin
      if (viol) begin
        m_cnt = 0;
        if (m_good == LOCK_FRAMES - 1) begin
          m_locked = 1'b1; m_good = 0; m_miss = 0;
        end else m_good++;
      end else m_good = 0;
    end else if (viol) begin
      m_good = 1; m_cnt = 0;
    end else m_cnt = nxt;
    lk = m_locked;
    fs = m_locked && (m_cnt == 0);
  endtask

  task automatic step(input bit tb, input bit tf, input bit zero, input bit viol, input bit both);
    bit eff, ep, en, rp, rn, lk, fs;
    string tt;
    exp_t x;
    eff = tx_offset_en ? h2 : tf;
    h2 = h1;
    h1 = tf;
    if (eff) begin
      ep = tx_last; en = !tx_last; tt = tx_offset_en ? "R4" : "R3";
    end else if (!tb) begin
      tx_last = !tx_last; ep = tx_last; en = !tx_last; tt = "R2";
    end else begin
      ep = 1'b0; en = 1'b0; tt = "R1";
    end
    if (both) begin rp = 1'b1; rn = 1'b1; end
    else if (viol) begin rp = g_last; rn = !g_last; end
    else if (zero) begin g_last = !g_last; rp = g_last; rn = !g_last; end
    else begin rp = 1'b0; rn = 1'b0; end
    lock_model(viol, lk, fs);
    x.b = !(both || viol || zero); x.v = viol; x.e = both; x.lk = lk; x.fs = fs;
    exp_q.push_back(x);
    @(negedge clk);
    tx_bit = tb; tx_frame = tf; rx_pos_i = rp; rx_neg_i = rn; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    // junk while the enable is low must be ignored (R11)
    rx_pos_i = 1'b1; rx_neg_i = 1'b1; tx_bit = 1'b0; tx_frame = 1'b1;
    chk(tt, tx_pos, ep, "tx_pos");
    chk(tt, tx_neg, en, "tx_neg");
    @(negedge clk);
    @(negedge clk);
    chk("R11", tx_pos, ep, "tx_pos held without bit_en");
  endtask

  always @(negedge clk) begin : monitor
    exp_t y;
    if (!rst && rx_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected rx_valid: actual 1 expected 0");
      end else begin
        y = exp_q.pop_front();
        chk("R5", rx_bit, y.b, "rx_bit");
        chk("R6", rx_viol, y.v, "rx_viol");
        chk("R7", rx_sym_err, y.e, "rx_sym_err");
        chk("R8 R9 R10", rx_locked, y.lk, "rx_locked");
        chk("R8", rx_frame_start, y.fs, "rx_frame_start");
      end
    end
  end

  function automatic bit rx_mark(input int f, input int i);
    return (f <= 4 && i == 0) || (f == 4 && i == 30) || (f == 7 && i == 0) ||
           (f == 8 && (i == 0 || i == 10)) || (f == 9 && i == 10) || (f == 10 && i == 10);
  endfunction

  initial begin : main
    rst = 1'b1; bit_en = 1'b0; tx_bit = 1'b1; tx_frame = 1'b0; tx_offset_en = 1'b0;
    rx_pos_i = 1'b0; rx_neg_i = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R12", tx_pos, 1'b0, "tx_pos after reset");
    chk("R12", tx_neg, 1'b0, "tx_neg after reset");
    chk("R12", rx_valid, 1'b0, "rx_valid after reset");
    chk("R12", rx_locked, 1'b0, "rx_locked after reset");
    chk("R12", rx_frame_start, 1'b0, "rx_frame_start after reset");
    for (int f = 0; f < 12; f++) begin
      for (int i = 0; i < FRAME_BITS; i++) begin
        int idx;
        bit both;
        idx = f * FRAME_BITS + i;
        tx_offset_en = (idx >= 6 * FRAME_BITS);
        both = (f == 3 && i == 20) || (f == 8 && i == 30);
        step(((idx / 2) % 3) == 0, (idx % FRAME_BITS) == 5,
             (i % 4 == 1) || (i % 4 == 2), rx_mark(f, i), both);
      end
    end
    repeat (4) @(negedge clk);
    chk("R11", exp_q.size() == 0, 1'b1, "all decoded bits delivered");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 watchdog expired: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule